// File: doc/BRIEF.md
# Dual Overflow Interval Timer

The block holds two identical 32-bit up-counters behind one word-addressed register bus. Each channel starts from a value that software loads and advances once per prescaled tick. When it steps past all-ones it reloads the start value, latches a pending flag and, if interrupts are enabled, raises its own level interrupt line. Software arms a timeout of about N ticks by loading all-ones minus N as the start value. A channel loaded with zero and left running serves as a free-running time base.

The control register has a load bit and a run bit. The load bit copies the start value into the counter and halts it. The run bit sets it going. Writing zero halts the counter and keeps its count. Counting also needs the enable bit in the configuration register. Channel 0 sits at byte offset 0x00 and channel 1 at 0x40. The bus uses a setup/access handshake that never stalls. This is a register port, so it carries no valid/ready back-pressure: every access finishes in its access cycle.

Top module: `ovf_timer_pair`

## Requirements
- R1: After reset every register of both channels reads 0, both channels are stopped, and both interrupt lines are low.
- R2: Each channel has six registers at fixed offsets. 0x00 is status, with the pending flag at bit 0. 0x04 is the count, read-only. 0x10 is control: bit 0 is load, and bit 1 is run, which reads back as 1 while started. 0x20 is configuration: bit 0 is count enable and bit 1 is interrupt enable. 0x24 is the divider and 0x28 is the start value. Configuration, divider and start value read back what was written, limited to their defined bits. Any other offset, including a misaligned one or an address outside both channels, reads 0.
- R3: Channel 1 answers at 0x40 plus the same offsets. It behaves like channel 0 and is independent of it, and it drives its own interrupt bit (irq[1]).
- R4: A control write with bit 0 set loads the counter from the start value and halts it, even if bit 1 is also set. A control write with only bit 1 set starts counting. A control write of 0 halts counting and leaves the count unchanged.
- R5: The counter advances only while it is started and configuration bit 0 is set. With divider value D it advances once every D+1 clocks. Counting starts at the edge after the start write commits. The edge that commits a halt or a disable still counts.
- R6: A tick taken at all-ones reloads the start value, sets the pending flag, and counting goes on from the start value.
- R7: Writing status with bit 0 set clears the pending flag. Writing status with bit 0 clear has no effect. An overflow in the same cycle as a clear leaves the flag set.
- R8: A channel's interrupt output is high exactly while its pending flag and its configuration bit 1 are both set.
- R9: Writes to the count register are ignored.
- R10: A transfer takes effect in the access cycle (select and enable both high). bus_ready is always 1. Read data is valid during the access cycle and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Transfer select (setup and access cycles) |
| bus_enable | input | 1 | Access-cycle marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data, valid in the access cycle |
| bus_ready | output | 1 | Transfer completion, always 1 |
| irq | output | NUM_INST (2) | Level interrupt per channel |

## Verification
The assertions watch these properties on every cycle:
- the pending flag rises only after the count was all-ones;
- a wrap goes back to the start value;
- a channel that is not counting keeps its count unless a control write lands;
- no interrupt appears without its enable;
- read data is quiet outside read access cycles.

Only the bench scenarios can show the following, because each depends on chosen programming sequences and an exact count of ticks:
- exact tick counts under different divider values;
- load taking priority over start;
- a write of 0 to status being ignored;
- writes to the count register being ignored;
- separation between the channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // width of the per-channel byte offset; channel stride is 2**OFS_W
  localparam int OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_STATUS = 6'h00;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 6'h10;
  localparam logic [OFS_W-1:0] OFS_CFG    = 6'h20;
  localparam logic [OFS_W-1:0] OFS_DIV    = 6'h24;
  localparam logic [OFS_W-1:0] OFS_INIT   = 6'h28;

  localparam int STAT_PEND_BIT = 0;
  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_RUN_BIT  = 1;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_IE_BIT    = 1;

  typedef struct packed {
    logic irq_en;
    logic en;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             at_limit;

  assign at_limit = (phase_q >= limit);
  assign tick     = active && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (active) begin
      phase_q <= at_limit ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode import tmr_pkg::*; #(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                bus_sel,
  input  logic                bus_enable,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_INST-1:0] wr_stb,
  output logic [NUM_INST-1:0] rd_stb,
  output logic [OFS_W-1:0]    ofs
);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic            xfer;
  logic [IDX_W-1:0] idx;

  assign xfer = bus_sel && bus_enable;
  assign idx  = bus_addr[ADDR_W-1:OFS_W];
  assign ofs  = bus_addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_INST; g++) begin : g_sel
    logic hit;
    assign hit       = (idx == IDX_W'(g));
    assign wr_stb[g] = xfer && bus_write && hit;
    assign rd_stb[g] = xfer && !bus_write && hit;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic [CNT_W-1:0] obs_count,
  output logic [CNT_W-1:0] obs_init,
  output logic             obs_pend,
  output logic             obs_irq_en,
  output logic             obs_active
);
  logic [CNT_W-1:0] count_q, init_q, div_q;
  logic             pend_q, run_q;
  tmr_cfg_t         cfg_q;

  logic wr_status, wr_ctrl, wr_cfg, wr_div, wr_init;
  logic ctrl_load, active, tick, wrap;

  assign wr_status = wr_stb && (ofs == OFS_STATUS);
  assign wr_ctrl   = wr_stb && (ofs == OFS_CTRL);
  assign wr_cfg    = wr_stb && (ofs == OFS_CFG);
  assign wr_div    = wr_stb && (ofs == OFS_DIV);
  assign wr_init   = wr_stb && (ofs == OFS_INIT);

  assign ctrl_load = wr_ctrl && wdata[CTRL_LOAD_BIT];
  assign active    = run_q && cfg_q.en;
  assign wrap      = tick && (count_q == '1);

  tmr_prescale #(.DIV_W(CNT_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ctrl_load),
    .active (active),
    .limit  (div_q),
    .tick   (tick)
  );

  // counter and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (ctrl_load)   count_q <= init_q;
      else if (wrap)   count_q <= init_q;
      else if (tick)   count_q <= count_q + 1'b1;
      if (wr_ctrl)     run_q   <= !wdata[CTRL_LOAD_BIT] && wdata[CTRL_RUN_BIT];
    end
  end

  // pending flag: a fresh wrap wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 pend_q <= 1'b0;
    else if (wrap)                              pend_q <= 1'b1;
    else if (wr_status && wdata[STAT_PEND_BIT]) pend_q <= 1'b0;
  end

  // programming registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q.en     <= wdata[CFG_EN_BIT];
        cfg_q.irq_en <= wdata[CFG_IE_BIT];
      end
      if (wr_div)  div_q  <= wdata;
      if (wr_init) init_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      unique case (ofs)
        OFS_STATUS: rdata[STAT_PEND_BIT] = pend_q;
        OFS_COUNT:  rdata = count_q;
        OFS_CTRL:   rdata[CTRL_RUN_BIT] = run_q;
        OFS_CFG:    rdata[1:0] = cfg_q;
        OFS_DIV:    rdata = div_q;
        OFS_INIT:   rdata = init_q;
        default:    rdata = '0;
      endcase
    end
  end

  assign irq        = pend_q && cfg_q.irq_en;
  assign obs_count  = count_q;
  assign obs_init   = init_q;
  assign obs_pend   = pend_q;
  assign obs_irq_en = cfg_q.irq_en;
  assign obs_active = active;
endmodule

// File: rtl/ovf_timer_pair.sv
module ovf_timer_pair import tmr_pkg::*; #(
  parameter int NUM_INST = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_enable,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  output logic                bus_ready,
  output logic [NUM_INST-1:0] irq
);
  logic [NUM_INST-1:0]            wr_stb, rd_stb;
  logic [OFS_W-1:0]               ofs;
  logic [NUM_INST-1:0][CNT_W-1:0] ch_rdata;
  logic [NUM_INST-1:0][CNT_W-1:0] count_vec, init_vec;
  logic [NUM_INST-1:0]            pend_vec, ie_vec, act_vec, ctrl_wr_vec;

  tmr_bus_decode #(.NUM_INST(NUM_INST), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .ofs        (ofs)
  );

  for (genvar g = 0; g < NUM_INST; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_stb[g]),
      .rd_stb     (rd_stb[g]),
      .ofs        (ofs),
      .wdata      (bus_wdata),
      .rdata      (ch_rdata[g]),
      .irq        (irq[g]),
      .obs_count  (count_vec[g]),
      .obs_init   (init_vec[g]),
      .obs_pend   (pend_vec[g]),
      .obs_irq_en (ie_vec[g]),
      .obs_active (act_vec[g])
    );
    assign ctrl_wr_vec[g] = wr_stb[g] && (ofs == OFS_CTRL);
  end

  // channels return zero unless addressed, so an OR merges them
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_INST; i++) bus_rdata = bus_rdata | ch_rdata[i];
  end

  assign bus_ready = 1'b1;
endmodule

// File: rtl/ovf_timer_pair_chk.sv
module ovf_timer_pair_chk #(
  parameter int NUM_INST = 2,
  parameter int CNT_W    = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_sel,
  input logic                            bus_enable,
  input logic                            bus_write,
  input logic [CNT_W-1:0]                bus_rdata,
  input logic [NUM_INST-1:0]             irq,
  input logic [NUM_INST-1:0][CNT_W-1:0]  count_vec,
  input logic [NUM_INST-1:0][CNT_W-1:0]  init_vec,
  input logic [NUM_INST-1:0]             pend_vec,
  input logic [NUM_INST-1:0]             ie_vec,
  input logic [NUM_INST-1:0]             act_vec,
  input logic [NUM_INST-1:0]             ctrl_wr_vec
);
  a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_enable && !bus_write) |-> (bus_rdata == '0));

  for (genvar g = 0; g < NUM_INST; g++) begin : g_chk
    a_r6_pend_after_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[g]) |-> ($past(count_vec[g]) == '1));

    a_r6_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_vec[g] == '1) && !ctrl_wr_vec[g]) |=>
        ((count_vec[g] == $past(count_vec[g])) ||
         ((count_vec[g] == $past(init_vec[g])) && pend_vec[g])));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_vec[g] && !ctrl_wr_vec[g]) |=> $stable(count_vec[g]));

    a_r8_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_vec[g] |-> !irq[g]);
  end
endmodule

bind ovf_timer_pair ovf_timer_pair_chk #(.NUM_INST(NUM_INST), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_enable  (bus_enable),
  .bus_write   (bus_write),
  .bus_rdata   (bus_rdata),
  .irq         (irq),
  .count_vec   (count_vec),
  .init_vec    (init_vec),
  .pend_vec    (pend_vec),
  .ie_vec      (ie_vec),
  .act_vec     (act_vec),
  .ctrl_wr_vec (ctrl_wr_vec)
);

// File: tb/ovf_timer_pair_tb_top.sv
module ovf_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  string       tag_q[$];
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;   // 50 MHz

  ovf_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
  );

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_enable = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_enable = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_checks++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // monitor: compares read data in the access cycle, clear of the edges
  always begin
    @(negedge clk);
    #2;
    if (bus_sel && bus_enable && !bus_write) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        string       t;
        logic [31:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h00, 0, "R1 status");
    bus_rd(8'h04, 0, "R1 count");
    bus_rd(8'h10, 0, "R1 ctrl");
    bus_rd(8'h20, 0, "R1 cfg");
    bus_rd(8'h24, 0, "R1 div");
    bus_rd(8'h28, 0, "R1 init");
    bus_rd(8'h44, 0, "R1 ch1 count");
    chk({30'd0, irq}, 0, "R1 irq");
    chk({31'd0, bus_ready}, 1, "R10 ready");

    // R2 readback and unmapped space
    bus_wr(8'h24, 32'h0000_00A5);
    bus_rd(8'h24, 32'h0000_00A5, "R2 div readback");
    bus_wr(8'h24, 0);
    bus_wr(8'h28, 32'h1234_5678);
    bus_rd(8'h28, 32'h1234_5678, "R2 init readback");
    bus_wr(8'h20, 32'hFFFF_FFFE);
    bus_rd(8'h20, 32'h2, "R2 cfg bits only");
    bus_wr(8'h20, 0);
    bus_rd(8'h08, 0, "R2 unmapped 08");
    bus_rd(8'h2C, 0, "R2 unmapped 2C");
    bus_rd(8'h05, 0, "R2 misaligned");
    bus_rd(8'h84, 0, "R2 beyond channels");
    bus_rd(8'hC4, 0, "R2 beyond channels hi");

    // R4 load dominates start, loaded counter stays halted
    bus_wr(8'h28, 32'hFFFF_FFF0);
    bus_wr(8'h10, 32'h3);
    bus_rd(8'h04, 32'hFFFF_FFF0, "R4 load value");
    bus_rd(8'h10, 0, "R4 load halts");
    bus_wr(8'h20, 32'h1);
    idle(4);
    bus_rd(8'h04, 32'hFFFF_FFF0, "R5 no count before start");

    // R5 counting, R4 stop keeps count
    bus_wr(8'h10, 32'h2);
    idle(2);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h04, 32'hFFFF_FFF5, "R5 five ticks");
    idle(3);
    bus_rd(8'h04, 32'hFFFF_FFF5, "R4 stop holds count");

    // R6 overflow with interrupt disabled
    bus_wr(8'h28, 32'hFFFF_FFFD);
    bus_wr(8'h10, 32'h1);
    bus_wr(8'h10, 32'h2);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h04, 32'hFFFF_FFFD, "R6 wrap reloads");
    bus_rd(8'h00, 32'h1, "R6 pending set");
    chk({30'd0, irq}, 0, "R8 irq masked");
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, 32'h1, "R7 zero write ignored");
    bus_wr(8'h20, 32'h3);
    chk({30'd0, irq}, 32'h1, "R8 irq follows enable");
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h00, 0, "R7 clear");
    chk({30'd0, irq}, 0, "R7 irq drops");

    // R6 counting continues past a wrap
    bus_wr(8'h10, 32'h2);
    idle(1);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h04, 32'hFFFF_FFFE, "R6 continues after wrap");
    chk({30'd0, irq}, 32'h1, "R8 irq on wrap");
    bus_wr(8'h00, 32'h1);

    // R9 count writes ignored
    bus_wr(8'h04, 32'h0000_1234);
    bus_rd(8'h04, 32'hFFFF_FFFE, "R9 count write ignored");

    // R5 divider of 3: 8 clocks give 2 ticks
    bus_wr(8'h28, 0);
    bus_wr(8'h10, 32'h1);
    bus_wr(8'h24, 32'h3);
    bus_wr(8'h10, 32'h2);
    idle(5);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h04, 32'h2, "R5 divider");

    // R5 disable freezes a started counter
    bus_wr(8'h24, 0);
    bus_wr(8'h10, 32'h2);
    idle(1);
    bus_wr(8'h20, 32'h0);
    idle(4);
    bus_rd(8'h04, 32'h6, "R5 disable freezes");
    bus_rd(8'h10, 32'h2, "R2 run readback");
    bus_wr(8'h10, 32'h0);

    // R3 second channel runs independently
    bus_wr(8'h60, 32'h1);
    bus_wr(8'h50, 32'h1);
    bus_wr(8'h50, 32'h2);
    idle(2);
    bus_wr(8'h50, 32'h0);
    bus_rd(8'h44, 32'h5, "R3 ch1 free run");
    bus_rd(8'h04, 32'h6, "R3 ch0 untouched");
    bus_wr(8'h68, 32'hFFFF_FFFF);
    bus_wr(8'h50, 32'h1);
    bus_wr(8'h60, 32'h3);
    bus_wr(8'h50, 32'h2);
    bus_wr(8'h50, 32'h0);
    bus_rd(8'h40, 32'h1, "R3 ch1 pending");
    bus_rd(8'h00, 0, "R3 ch0 not pending");
    chk({30'd0, irq}, 32'h2, "R3 own irq line");
    bus_wr(8'h40, 32'h1);
    chk({30'd0, irq}, 0, "R7 ch1 clear");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule